// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a three-wire link to a 12-bit serial-output converter. The converter is selected by an active-low chip select, clocked by a serial clock that the block generates, and returns its result on a single data line. On a read request the block runs one sixteen-edge frame. It takes the twelve result bits out of a stream that carries two zero bits before them and two zero bits after them. At the end of the frame it presents the result together with a one-cycle strobe.

A second request input runs a short frame instead. In that frame chip select is released after the fourth falling serial-clock edge. That point lies inside the window in which the converter treats the release as a request to power down. After every frame the block keeps chip select high for a programmable number of system clock cycles, which gives the converter its acquisition time. The serial-clock half period is a programmable number of system clock cycles. Both settings are latched when a request is accepted.

The control is one state machine with five states. In IDLE chip select is high and the block accepts requests. SETUP is the first half period with chip select low and the serial clock still high. LOW and HIGH are the two halves of each serial-clock period. GAP is the enforced chip-select high time. The transitions are:
- IDLE→SETUP on an accepted request.
- SETUP→LOW on a half-period expiry; this is falling edge 1.
- LOW→HIGH on a half-period expiry; this is a rising edge, and the data line is sampled here.
- HIGH→LOW on a half-period expiry; this is the next falling edge.
- LOW→GAP on the expiry that produces the frame's last rising edge; chip select rises at the same moment.
- GAP→IDLE when the gap count expires.

Top module: `adc_frame_reader`

## Requirements
- R1: Out of reset, and whenever chip select is high, cs_n_o and sclk_o are 1, and valid_o is 0. Out of reset busy_o is 0.
- R2: A request taken in IDLE drives cs_n_o low on the next clock. busy_o is 1 from that clock until the gap wait ends.
- R3: The first falling edge of sclk_o comes max(div_i,1) clocks after cs_n_o falls. After that, falling edges are 2*max(div_i,1) clocks apart. div_i is latched when the request is accepted.
- R4: A read frame has exactly 16 falling and 16 rising sclk_o edges. cs_n_o rises together with the 16th rising edge, so it stays low past the 13th.
- R5: sdo_i is sampled at rising edges 2 to 13, and the bit sampled at rising edge 2 becomes bit 11 (MSB) of data_o. Bits at rising edges 1, 14, 15 and 16 are discarded. valid_o pulses for one clock as cs_n_o rises.
- R6: pdown_i runs a frame of 4 falling and 4 rising edges. cs_n_o rises with the 4th rising edge, and no valid_o is produced. pdown_i wins when both requests are high together.
- R7: After every frame cs_n_o stays high for at least max(gap_i,1) clocks, and busy_o stays 1 during that time. gap_i is latched when the request is accepted.
- R8: start_i and pdown_i are ignored while busy_o is 1.
- R9: data_o holds its last result until the next read frame ends; a power-down frame leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Read-frame request, sampled in IDLE |
| pdown_i | input | 1 | Power-down-frame request, sampled in IDLE |
| div_i | input | 8 | Serial-clock half period in clocks (0 acts as 1) |
| gap_i | input | 10 | Minimum chip-select high time in clocks (0 acts as 1) |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| busy_o | output | 1 | Frame or gap in progress |
| data_o | output | 12 | Last captured result |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
The read frames use the codes 0xA5A and 0x5A5 for alternating bits, 0xFFF and 0x000 for all-ones and all-zeros, 0x800 and 0x001 for lone end bits, and 0x7FE for an inner run. An off-by-one sample position or a reversed bit order fails the end-bit codes. The alternating codes show whether a padding zero was taken in. Runs at half periods of 1 to 4 clocks and gaps of 0 to 20 clocks tell a correct divider and gap counter apart from fixed timing. Two power-down frames, one of them requested together with a read, check the frame length, the priority and that data_o is left alone. Extra requests made during a frame must not add a frame.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } rd_state_e;

endpackage

// File: rtl/adcrd_timer.sv
// Free-running interval counter: while run is high it expires every
// max(limit,1) cycles and restarts; it is held at zero otherwise.
module adcrd_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expire
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] lim_m1;

    assign lim_m1 = (limit == '0) ? '0 : (limit - W'(1));
    assign expire = run && (cnt_q == lim_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= lim_m1));

endmodule

// File: rtl/adcrd_capture.sv
// Shifts in the data-bearing rising-edge samples and publishes the word.
module adcrd_capture #(
    parameter int DATA_W = 12,
    parameter int FIRST  = 2,
    parameter int EW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [EW-1:0]     edge_idx,
    input  logic              sdo,
    input  logic              publish,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);

    localparam int LAST = FIRST + DATA_W - 1;

    logic [DATA_W-1:0] shreg_q;
    logic              in_window;

    assign in_window = (edge_idx >= EW'(FIRST)) && (edge_idx <= EW'(LAST));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            if (sample && in_window) begin
                shreg_q <= {shreg_q[DATA_W-2:0], sdo};
            end
            valid_o <= publish;
            if (publish) begin
                data_o <= shreg_q;
            end
        end
    end

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

endmodule

// File: rtl/adcrd_fsm.sv
// Frame state machine: chip select, serial clock, edge counting and
// the timer hand-off.
module adcrd_fsm
    import adcrd_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int GAP_W       = 10,
    parameter int FRAME_EDGES = 16,
    parameter int PD_EDGE     = 4,
    parameter int EW          = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             pdown_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [GAP_W-1:0] gap_i,
    input  logic             half_exp,
    input  logic             gap_exp,
    output logic [DIV_W-1:0] div_q,
    output logic [GAP_W-1:0] gap_q,
    output logic             half_run,
    output logic             gap_run,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             busy_o,
    output logic             sample_o,
    output logic [EW-1:0]    edge_o,
    output logic             publish_o
);

    rd_state_e     state_q, state_d;
    logic [EW-1:0] edge_q;
    logic          pd_q;
    logic          accept;
    logic [EW-1:0] last_edge;

    assign accept    = (state_q == ST_IDLE) && (start_i || pdown_i);
    assign last_edge = pd_q ? EW'(PD_EDGE) : EW'(FRAME_EDGES);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)   state_d = ST_SETUP;
            ST_SETUP: if (half_exp) state_d = ST_LOW;
            ST_LOW:   if (half_exp) state_d = (edge_q == last_edge) ? ST_GAP : ST_HIGH;
            ST_HIGH:  if (half_exp) state_d = ST_LOW;
            ST_GAP:   if (gap_exp)  state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '0;
            pd_q   <= 1'b0;
            div_q  <= '0;
            gap_q  <= '0;
        end else begin
            if (accept) begin
                pd_q  <= pdown_i;
                div_q <= div_i;
                gap_q <= gap_i;
            end
            if (state_q == ST_SETUP && half_exp) begin
                edge_q <= EW'(1);
            end else if (state_q == ST_HIGH && half_exp) begin
                edge_q <= edge_q + EW'(1);
            end
        end
    end

    always_comb begin
        cs_n_o   = 1'b1;
        sclk_o   = 1'b1;
        busy_o   = 1'b1;
        half_run = 1'b0;
        gap_run  = 1'b0;
        sample_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
            end
            ST_SETUP: begin
                cs_n_o   = 1'b0;
                half_run = 1'b1;
            end
            ST_LOW: begin
                cs_n_o   = 1'b0;
                sclk_o   = 1'b0;
                half_run = 1'b1;
                sample_o = half_exp;
            end
            ST_HIGH: begin
                cs_n_o   = 1'b0;
                half_run = 1'b1;
            end
            ST_GAP: begin
                gap_run = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

    assign edge_o    = edge_q;
    assign publish_o = sample_o && (edge_q == last_edge) && !pd_q;

    // R1
    idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);

    // R4
    edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (edge_q == (pd_q ? EW'(PD_EDGE) : EW'(FRAME_EDGES))));

    // R6
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> ($past(publish_o) != pd_q));

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_SETUP) |=> (state_q != ST_SETUP));

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
    parameter int DATA_W     = 12,
    parameter int LEAD_BITS  = 2,
    parameter int TRAIL_BITS = 2,
    parameter int PD_EDGE    = 4,
    parameter int DIV_W      = 8,
    parameter int GAP_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pdown_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [GAP_W-1:0]  gap_i,
    input  logic              sdo_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);

    localparam int FRAME_EDGES = LEAD_BITS + DATA_W + TRAIL_BITS;
    localparam int EW          = $clog2(FRAME_EDGES + 1);

    logic             half_exp, gap_exp, half_run, gap_run;
    logic [DIV_W-1:0] div_q;
    logic [GAP_W-1:0] gap_q;
    logic             sample;
    logic [EW-1:0]    edge_idx;
    logic             publish;

    adcrd_fsm #(
        .DIV_W       (DIV_W),
        .GAP_W       (GAP_W),
        .FRAME_EDGES (FRAME_EDGES),
        .PD_EDGE     (PD_EDGE),
        .EW          (EW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .pdown_i   (pdown_i),
        .div_i     (div_i),
        .gap_i     (gap_i),
        .half_exp  (half_exp),
        .gap_exp   (gap_exp),
        .div_q     (div_q),
        .gap_q     (gap_q),
        .half_run  (half_run),
        .gap_run   (gap_run),
        .cs_n_o    (cs_n_o),
        .sclk_o    (sclk_o),
        .busy_o    (busy_o),
        .sample_o  (sample),
        .edge_o    (edge_idx),
        .publish_o (publish)
    );

    adcrd_timer #(.W(DIV_W)) u_half_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (half_run),
        .limit  (div_q),
        .expire (half_exp)
    );

    adcrd_timer #(.W(GAP_W)) u_gap_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (gap_run),
        .limit  (gap_q),
        .expire (gap_exp)
    );

    adcrd_capture #(
        .DATA_W (DATA_W),
        .FIRST  (LEAD_BITS),
        .EW     (EW)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sample),
        .edge_idx (edge_idx),
        .sdo      (sdo_i),
        .publish  (publish),
        .data_o   (data_o),
        .valid_o  (valid_o)
    );

    // R2
    cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);

endmodule

// File: tb/test_adc_frame_reader.sv
module test_adc_frame_reader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        pdown_i = 1'b0;
    logic [7:0]  div_i = 8'd1;
    logic [9:0]  gap_i = 10'd0;
    logic        sdo_r = 1'b0;
    logic        cs_n_o, sclk_o, busy_o, valid_o;
    logic [11:0] data_o;

    always #2 clk = ~clk;

    adc_frame_reader i_adc_frame_reader (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .pdown_i (pdown_i),
        .div_i   (div_i),
        .gap_i   (gap_i),
        .sdo_i   (sdo_r),
        .cs_n_o  (cs_n_o),
        .sclk_o  (sclk_o),
        .busy_o  (busy_o),
        .data_o  (data_o),
        .valid_o (valid_o)
    );

    int nchk = 0;
    int nfail = 0;
    logic [11:0] exp_q[$];
    logic [11:0] adc_val = '0;
    int exp_div = 1, exp_gap = 0, last_gap = 0;
    bit exp_pd = 0;
    int frames = 0, valids = 0, idle_bad = 0;
    int cyc = 0, hi_cnt = 0, falls = 0, rises = 0, t_csf = 0, t_fall = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int max1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic logic bit_at(input int pos, input logic [11:0] v);
        if (pos >= 2 && pos <= 13) return v[13-pos];
        return 1'b0;
    endfunction

    // converter model and monitor/scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!prev_cs && prev_sclk && !sclk_o && !cs_n_o) begin
                falls++;
                sdo_r = bit_at(falls, adc_val);
                if (falls == 1) chk(cyc - t_csf == max1(exp_div), "R3 first fall", cyc - t_csf, max1(exp_div));
                else chk(cyc - t_fall == 2 * max1(exp_div), "R3 period", cyc - t_fall, 2 * max1(exp_div));
                t_fall = cyc;
            end
            if (!prev_cs && !prev_sclk && sclk_o) rises++;
            if (!prev_cs && cs_n_o) begin
                hi_cnt = 0;
                last_gap = exp_gap;
                if (exp_pd) begin
                    chk(falls == 4 && rises == 4, "R6 pd edges", falls * 100 + rises, 404);
                end else begin
                    chk(falls == 16 && rises == 16, "R4 frame edges", falls * 100 + rises, 1616);
                end
            end
            if (cs_n_o) begin
                hi_cnt++;
                if (!sclk_o || valid_o && prev_cs) idle_bad++;
            end
            if (prev_cs && !cs_n_o) begin
                frames++;
                if (frames > 1) chk(hi_cnt >= max1(last_gap), "R7 cs high time", hi_cnt, max1(last_gap));
                falls = 0; rises = 0; t_csf = cyc;
                sdo_r = 1'b0;
            end
            if (valid_o) begin
                valids++;
                if (exp_q.size() == 0) begin
                    chk(0, "R6 unexpected valid", 1, 0);
                end else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    chk(data_o == e, "R5 data", data_o, e);
                end
            end
            prev_cs = cs_n_o;
            prev_sclk = sclk_o;
        end
    end

    task automatic do_req(input bit pd, input bit both, input logic [11:0] val,
                          input int div, input int gap, input bit poke);
        while (busy_o) @(negedge clk);
        adc_val = val; exp_div = div; exp_gap = gap; exp_pd = pd;
        div_i = div[7:0]; gap_i = gap[9:0];
        if (!pd) exp_q.push_back(val);
        start_i = !pd || both;
        pdown_i = pd;
        @(negedge clk);
        start_i = 1'b0; pdown_i = 1'b0;
        div_i = 8'd7; gap_i = 10'd50;  // changes after acceptance must not matter
        chk(busy_o && !cs_n_o, "R2 busy and cs after request", {busy_o, cs_n_o}, 2'b10);
        if (poke) begin
            repeat (10) @(negedge clk);
            start_i = 1'b1; pdown_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0; pdown_i = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n_o && sclk_o, "R1 reset cs/sclk", {cs_n_o, sclk_o}, 2'b11);
        chk(!busy_o, "R1 reset busy", busy_o, 0);
        chk(!valid_o, "R1 reset valid", valid_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(data_o == 12'h000, "R1 reset data", data_o, 0);

        do_req(0, 0, 12'hA5A, 1, 0, 0);
        do_req(0, 0, 12'h5A5, 2, 5, 0);
        do_req(0, 0, 12'hFFF, 3, 20, 0);
        do_req(0, 0, 12'h000, 1, 1, 0);
        do_req(1, 0, 12'h3C3, 2, 8, 0);
        while (busy_o) @(negedge clk);
        chk(data_o == 12'h000, "R9 data kept after pd frame", data_o, 12'h000);
        do_req(0, 0, 12'h800, 1, 3, 1);   // R8 requests during the frame
        do_req(1, 1, 12'h555, 1, 2, 0);   // R6 priority of pdown_i
        while (busy_o) @(negedge clk);
        chk(data_o == 12'h800, "R9 data kept after priority pd frame", data_o, 12'h800);
        do_req(0, 0, 12'h001, 4, 0, 0);
        do_req(0, 0, 12'h7FE, 1, 0, 0);
        while (busy_o) @(negedge clk);
        repeat (5) @(negedge clk);

        chk(frames == 9, "R8 frame count", frames, 9);
        chk(valids == 7, "R5 valid count", valids, 7);
        chk(exp_q.size() == 0, "R5 pending results", exp_q.size(), 0);
        chk(idle_bad == 0, "R1 sclk high while deselected", idle_bad, 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R2 watchdog expired actual=busy expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule